// File: doc/BRIEF.md
# Binary Buddy Block Allocator

This block hands out and takes back pieces of a memory region of 2^K minimum-size units. Every piece is a power of two in size and starts at an address that is a multiple of its size. A client asks for a number of units and gets back a base address and an order, where the order is log2 of the granted size. The client returns a piece by giving the same base address and order.

The region is held as a complete binary tree. Each node is either unused, free, split or allocated. An allocation that finds no free piece of the right size halves a larger piece again and again until one of the right size exists. A release joins the piece with its buddy, one order at a time, for as long as the buddy is entirely free. Requests go in one at a time through a busy/done handshake. Splitting and merging each take one cycle per order walked.

Top module: `buddy_alloc`

## Requirements
- R1: After reset `busy` and `done` are low and the whole region is one free piece of order K: a request of 2^K units then returns address 0 and order K.
- R2: A request of `size` units is rounded up to order o, the smallest o with 2^o >= size. A size of 0 is treated as one unit (order 0).
- R3: If a free piece of exactly order o exists, the one with the lowest base address is granted and no other piece changes.
- R4: If no piece of order o is free, the allocator takes the smallest order above o that has a free piece, and the lowest-addressed piece at that order. It halves that piece down to order o and grants the lower half at each step. The upper halves are left free at orders o to j-1.
- R5: A request larger than 2^K units, or one with no free piece of order o or above, completes with `fail`=1, `res_addr`=0, `res_order`=0 and no change of state.
- R6: A valid release frees the piece and merges it with its buddy (base XOR 2^order) while that buddy is wholly free, repeating at each higher order. `res_addr`/`res_order` report the resulting free piece.
- R7: A released piece never merges with a free neighbour that is not its buddy, so the neighbour and the piece stay separate free pieces.
- R8: A release whose order exceeds K, whose address is not a multiple of 2^order, or that does not name a currently allocated piece completes with `err`=1, `res_addr`=0, `res_order`=0 and no change of state.
- R9: A request is taken only while `busy` is low. If both request lines are high in the same cycle, the allocation is served and the release is dropped. `done` marks each completion for one cycle, with `busy` low. Every granted base address is a multiple of 2^`res_order`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Allocation request, taken when busy is low |
| alloc_size | input | K+1 | Requested size in units |
| free_req | input | 1 | Release request, taken when busy is low and alloc_req is low |
| free_addr | input | K | Base address of the piece to release |
| free_order | input | clog2(K+1) | Order of the piece to release |
| busy | output | 1 | A split or merge walk is in progress |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | Allocation could not be served (valid with done) |
| err | output | 1 | Release was invalid (valid with done) |
| res_addr | output | K | Granted base, or base of the merged free piece |
| res_order | output | clog2(K+1) | Granted order, or order of the merged free piece |

## Verification
Directed sequences cover several cases that are easy to tell apart: a request that fits an existing piece exactly, requests that force splits of different depths, oversize and exhausted requests, releases that merge several levels, a release whose free neighbour is not its buddy, and misaligned, wrong-order or repeated releases. Randomly sized requests mixed with releases of live pieces and of arbitrary address/order pairs then push the tree into fragmented states. A free-list model in the bench predicts address, order and flags for every completion, so a wrong choice of order or address, or a merge that goes one level too far or stops one level short, shows up in the reported results.

// File: rtl/buddy_pkg.sv
// Shared encodings for the buddy allocator.
// Assumes: node state fits two bits; controller has three phases.
package buddy_pkg;
    typedef enum logic [1:0] {
        ND_UNUSED = 2'd0,   // lies under a free or allocated ancestor
        ND_FREE   = 2'd1,
        ND_SPLIT  = 2'd2,
        ND_ALLOC  = 2'd3
    } node_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_SPLIT = 2'd1,
        FS_MERGE = 2'd2
    } fsm_t;
endpackage

// File: rtl/buddy_round.sv
// Rounds a unit count up to a power-of-two order.
// Assumes: size 0 maps to order 0; sizes above 2^K flag too_big.
module buddy_round #(
    parameter int K  = 4,
    parameter int SW = K + 1,
    parameter int OW = $clog2(K + 1)
) (
    input  logic [SW-1:0] size,
    output logic [OW-1:0] ord,
    output logic          too_big
);
    // Smallest order whose block holds the request.
    always_comb begin
        ord     = OW'(K);
        too_big = size > (SW'(1) << K);
        for (int o = K; o >= 0; o--) begin
            if (size <= (SW'(1) << o)) ord = OW'(o);
        end
    end
endmodule

// File: rtl/buddy_level_find.sv
// Finds the lowest-addressed free node on one tree level.
// Assumes: lvl_st holds the 2^LVL node states of level LVL, leftmost node in the low bits.
module buddy_level_find
    import buddy_pkg::*;
#(
    parameter int K   = 4,
    parameter int LVL = 0,
    parameter int NW  = K + 1,
    parameter int CNT = 2 ** LVL
) (
    input  logic [2*CNT-1:0] lvl_st,
    output logic             found,
    output logic [NW-1:0]    node
);
    // Priority scan, lowest index wins.
    always_comb begin
        found = 1'b0;
        node  = NW'(CNT);
        for (int i = CNT - 1; i >= 0; i--) begin
            if (lvl_st[2*i +: 2] == ND_FREE) begin
                found = 1'b1;
                node  = NW'(CNT + i);
            end
        end
    end
endmodule

// File: rtl/buddy_alloc.sv
// Binary buddy allocator over 2^K units.
// Node i (heap order, root 1) on level L covers base (i-2^L)<<(K-L), order K-L.
// Assumes: one request at a time; requests are sampled only while busy is low;
// allocation wins over release in the same cycle.
module buddy_alloc
    import buddy_pkg::*;
#(
    parameter int K     = 4,
    parameter int AW    = K,
    parameter int SW    = K + 1,
    parameter int OW    = $clog2(K + 1),
    parameter int NW    = K + 1,
    parameter int NODES = 2 ** (K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic [SW-1:0] alloc_size,
    input  logic          free_req,
    input  logic [AW-1:0] free_addr,
    input  logic [OW-1:0] free_order,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          err,
    output logic [AW-1:0] res_addr,
    output logic [OW-1:0] res_order
);
    logic [2*NODES-1:0] tree_q;
    fsm_t               fsm_q;
    logic [NW-1:0]      cur_q;
    logic [OW-1:0]      lvl_q;
    logic [OW-1:0]      tgt_q;

    logic [OW-1:0] rq_ord;
    logic          rq_big;
    logic [K:0]    lv_found;
    logic [NW-1:0] lv_node [K+1];

    buddy_round #(.K(K), .SW(SW), .OW(OW)) u_round (
        .size(alloc_size), .ord(rq_ord), .too_big(rq_big)
    );

    for (genvar l = 0; l <= K; l++) begin : g_lvl
        buddy_level_find #(.K(K), .LVL(l), .NW(NW)) u_find (
            .lvl_st(tree_q[2*(2**l) +: 2*(2**l)]),
            .found (lv_found[l]),
            .node  (lv_node[l])
        );
    end

    // Base address of a node given its level.
    function automatic logic [AW-1:0] node_base(input logic [NW-1:0] idx, input logic [OW-1:0] lvl);
        logic [NW-1:0] off;
        off = idx - (NW'(1) << lvl);
        return AW'(off << (OW'(K) - lvl));
    endfunction

    logic [OW-1:0] tgt_lvl;
    logic          exact;
    logic          have_big;
    logic [OW-1:0] src_lvl;

    // Pick exact-fit or the smallest larger free piece.
    always_comb begin
        tgt_lvl  = OW'(K) - rq_ord;
        exact    = lv_found[tgt_lvl];
        have_big = 1'b0;
        src_lvl  = '0;
        for (int l = 0; l <= K; l++) begin
            if (OW'(l) < tgt_lvl && lv_found[l]) begin
                have_big = 1'b1;
                src_lvl  = OW'(l);
            end
        end
    end

    logic          fr_ok_ord;
    logic          fr_aligned;
    logic [OW-1:0] fr_lvl;
    logic [NW-1:0] fr_node;
    logic          fr_valid;

    // Locate and vet the node a release names.
    always_comb begin
        fr_ok_ord  = free_order <= OW'(K);
        fr_aligned = (free_addr & ((AW'(1) << free_order) - AW'(1))) == '0;
        fr_lvl     = OW'(K) - free_order;
        fr_node    = fr_ok_ord ? ((NW'(1) << fr_lvl) | NW'(free_addr >> free_order)) : NW'(1);
        fr_valid   = fr_ok_ord && fr_aligned && (tree_q[2*int'(fr_node) +: 2] == ND_ALLOC);
    end

    logic [NW-1:0] child_l, child_r, sib, par;

    // Neighbour indices of the walk pointer.
    always_comb begin
        child_l = cur_q << 1;
        child_r = child_l | NW'(1);
        sib     = cur_q ^ NW'(1);
        par     = cur_q >> 1;
    end

    // Controller and node-state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tree_q        <= '0;
            tree_q[3:2]   <= ND_FREE;
            fsm_q         <= FS_IDLE;
            cur_q         <= NW'(1);
            lvl_q         <= '0;
            tgt_q         <= '0;
            done          <= 1'b0;
            fail          <= 1'b0;
            err           <= 1'b0;
            res_addr      <= '0;
            res_order     <= '0;
        end else begin
            done <= 1'b0;
            case (fsm_q)
                FS_IDLE: begin
                    if (alloc_req) begin
                        if (rq_big || (!exact && !have_big)) begin
                            done <= 1'b1; fail <= 1'b1; err <= 1'b0;
                            res_addr <= '0; res_order <= '0;
                        end else if (exact) begin
                            tree_q[2*int'(lv_node[tgt_lvl]) +: 2] <= ND_ALLOC;
                            done <= 1'b1; fail <= 1'b0; err <= 1'b0;
                            res_addr  <= node_base(lv_node[tgt_lvl], tgt_lvl);
                            res_order <= rq_ord;
                        end else begin
                            cur_q <= lv_node[src_lvl];
                            lvl_q <= src_lvl;
                            tgt_q <= tgt_lvl;
                            fsm_q <= FS_SPLIT;
                        end
                    end else if (free_req) begin
                        if (!fr_valid) begin
                            done <= 1'b1; fail <= 1'b0; err <= 1'b1;
                            res_addr <= '0; res_order <= '0;
                        end else begin
                            tree_q[2*int'(fr_node) +: 2] <= ND_FREE;
                            cur_q <= fr_node;
                            lvl_q <= fr_lvl;
                            fsm_q <= FS_MERGE;
                        end
                    end
                end
                FS_SPLIT: begin
                    if (lvl_q == tgt_q) begin
                        tree_q[2*int'(cur_q) +: 2] <= ND_ALLOC;
                        done <= 1'b1; fail <= 1'b0; err <= 1'b0;
                        res_addr  <= node_base(cur_q, lvl_q);
                        res_order <= OW'(K) - lvl_q;
                        fsm_q <= FS_IDLE;
                    end else begin
                        tree_q[2*int'(cur_q) +: 2]   <= ND_SPLIT;
                        tree_q[2*int'(child_l) +: 2] <= ND_FREE;
                        tree_q[2*int'(child_r) +: 2] <= ND_FREE;
                        cur_q <= child_l;
                        lvl_q <= lvl_q + OW'(1);
                    end
                end
                FS_MERGE: begin
                    if (cur_q != NW'(1) && tree_q[2*int'(sib) +: 2] == ND_FREE) begin
                        tree_q[2*int'(cur_q) +: 2] <= ND_UNUSED;
                        tree_q[2*int'(sib) +: 2]   <= ND_UNUSED;
                        tree_q[2*int'(par) +: 2]   <= ND_FREE;
                        cur_q <= par;
                        lvl_q <= lvl_q - OW'(1);
                    end else begin
                        done <= 1'b1; fail <= 1'b0; err <= 1'b0;
                        res_addr  <= node_base(cur_q, lvl_q);
                        res_order <= OW'(K) - lvl_q;
                        fsm_q <= FS_IDLE;
                    end
                end
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end

    assign busy = fsm_q != FS_IDLE;
endmodule

// File: rtl/buddy_alloc_chk.sv
// Property checker for buddy_alloc, bound to every instance.
// Assumes: tree is the packed node-state vector, two bits per heap node.
module buddy_alloc_chk
    import buddy_pkg::*;
#(
    parameter int K     = 4,
    parameter int OW    = $clog2(K + 1),
    parameter int NODES = 2 ** (K + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_req,
    input logic               free_req,
    input logic               busy,
    input logic               done,
    input logic               fail,
    input logic               err,
    input logic [K-1:0]       res_addr,
    input logic [OW-1:0]      res_order,
    input logic [2*NODES-1:0] tree
);
    logic pair_free;

    // Flags any pair of buddies that are both free.
    always_comb begin
        pair_free = 1'b0;
        for (int i = 2; i < NODES; i += 2) begin
            if (tree[2*i +: 2] == ND_FREE && tree[2*(i+1) +: 2] == ND_FREE) pair_free = 1'b1;
        end
    end

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(alloc_req || free_req));
    // R9
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && !err) |-> (((res_addr >> res_order) << res_order) == res_addr));
    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !(fail && err));
    // R6
    no_free_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !pair_free);
    // R2
    order_range_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> res_order <= OW'(K));
endmodule

bind buddy_alloc buddy_alloc_chk #(.K(K), .OW(OW), .NODES(NODES)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .free_req(free_req),
    .busy(busy), .done(done), .fail(fail), .err(err),
    .res_addr(res_addr), .res_order(res_order), .tree(tree_q)
);

// File: tb/buddy_alloc_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// each completion compared with a free-list model built from the requirements.
module buddy_alloc_tb;
    localparam int K     = 4;
    localparam int UNITS = 2 ** K;
    localparam int OW    = $clog2(K + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic [K:0]    alloc_size = '0;
    logic          free_req = 1'b0;
    logic [K-1:0]  free_addr = '0;
    logic [OW-1:0] free_order = '0;
    logic          busy, done, fail, err;
    logic [K-1:0]  res_addr;
    logic [OW-1:0] res_order;

    int n_checks = 0;
    int n_fails  = 0;

    bit fm [0:K][0:UNITS-1];   // model: free pieces by order and base
    bit am [0:K][0:UNITS-1];   // model: allocated pieces by order and base

    buddy_alloc #(.K(K)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_size(alloc_size),
        .free_req(free_req), .free_addr(free_addr), .free_order(free_order),
        .busy(busy), .done(done), .fail(fail), .err(err),
        .res_addr(res_addr), .res_order(res_order)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int o = 0; o <= K; o++)
            for (int a = 0; a < UNITS; a++) begin fm[o][a] = 0; am[o][a] = 0; end
        fm[K][0] = 1;
    endtask

    task automatic model_alloc(input int sz, output bit f, output int a, output int o);
        int j;
        bit hit;
        o = 0;
        while ((1 << o) < sz) o++;
        f = 0; a = 0; hit = 0;
        if (o > K) begin f = 1; o = 0; return; end
        for (j = o; j <= K && !hit; j++) begin
            for (int b = 0; b < UNITS && !hit; b += (1 << j))
                if (fm[j][b]) begin hit = 1; a = b; end
            if (hit) begin
                fm[j][a] = 0;
                for (int k = j - 1; k >= o; k--) fm[k][a + (1 << k)] = 1;
                am[o][a] = 1;
            end
        end
        if (!hit) begin f = 1; a = 0; o = 0; end
    endtask

    task automatic model_free(input int a, input int o, output bit e, output int ra, output int ro);
        e = 0; ra = 0; ro = 0;
        if (o > K || (a % (1 << o)) != 0) begin e = 1; return; end
        if (!am[o][a]) begin e = 1; return; end
        am[o][a] = 0;
        while (o < K && fm[o][a ^ (1 << o)]) begin
            fm[o][a ^ (1 << o)] = 0;
            a = a & ~(1 << o);
            o++;
        end
        fm[o][a] = 1;
        ra = a; ro = o;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 64) begin @(negedge clk); n++; end
        if (!done) check(0, {tag, " done timeout (R9)"}, 0, 1);
    endtask

    task automatic do_alloc(input int sz, input string tag);
        bit ef; int ea, eo;
        model_alloc(sz, ef, ea, eo);
        @(negedge clk);
        alloc_req = 1'b1; alloc_size = (K+1)'(sz);
        @(negedge clk);
        alloc_req = 1'b0;
        wait_done(tag);
        check({fail, err, res_addr, res_order} == {ef, 1'b0, K'(ea), OW'(eo)}, tag,
              int'({fail, err, res_addr, res_order}), int'({ef, 1'b0, K'(ea), OW'(eo)}));
    endtask

    task automatic do_free(input int a, input int o, input string tag);
        bit ee; int ra, ro;
        model_free(a, o, ee, ra, ro);
        @(negedge clk);
        free_req = 1'b1; free_addr = K'(a); free_order = OW'(o);
        @(negedge clk);
        free_req = 1'b0;
        wait_done(tag);
        check({fail, err, res_addr, res_order} == {1'b0, ee, K'(ra), OW'(ro)}, tag,
              int'({fail, err, res_addr, res_order}), int'({1'b0, ee, K'(ra), OW'(ro)}));
    endtask

    // Both request lines together: only the allocation is served (R9).
    task automatic do_both(input int sz, input int a, input int o);
        bit ef; int ea, eo;
        model_alloc(sz, ef, ea, eo);
        @(negedge clk);
        alloc_req = 1'b1; alloc_size = (K+1)'(sz);
        free_req = 1'b1; free_addr = K'(a); free_order = OW'(o);
        @(negedge clk);
        alloc_req = 1'b0; free_req = 1'b0;
        wait_done("R9 both");
        check({fail, err, res_addr, res_order} == {ef, 1'b0, K'(ea), OW'(eo)}, "R9 alloc wins",
              int'({fail, err, res_addr, res_order}), int'({ef, 1'b0, K'(ea), OW'(eo)}));
    endtask

    task automatic random_free();
        int ca [80]; int co [80]; int nc = 0;
        for (int o = 0; o <= K; o++)
            for (int a = 0; a < UNITS; a++)
                if (am[o][a]) begin ca[nc] = a; co[nc] = o; nc++; end
        if (nc > 0 && $urandom_range(0, 9) < 7) begin
            int p = $urandom_range(0, nc - 1);
            do_free(ca[p], co[p], "R6 random release");
        end else begin
            do_free($urandom_range(0, UNITS - 1), $urandom_range(0, K + 1), "R8 random release");
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 reset idle", int'({busy, done}), 0);

        do_alloc(UNITS, "R1 whole region");
        do_free(0, K, "R6 whole region back");

        do_alloc(6, "R2 round 6 to 8, R4 split");
        do_alloc(0, "R2 size zero");
        do_alloc(2, "R3 exact fit");
        do_alloc(UNITS + 1, "R5 oversize");
        do_alloc(UNITS, "R5 no room");
        do_free(8, 3, "R8 wrong order");
        do_free(9, 0, "R8 not allocated");
        do_free(10, 2, "R8 misaligned");
        do_free(8, 0, "R6 merge one level");
        do_free(10, 1, "R6 merge several levels");

        do_alloc(4, "R4 split to four");
        do_alloc(4, "R3 second four");
        do_free(0, 3, "R7 blocked by split buddy");
        do_free(8, 2, "R7 non-buddy neighbour free");
        do_alloc(8, "R7 lower eight");
        do_alloc(8, "R7 no joined eight");
        do_free(8, 2, "R8 double release");

        do_both(1, 12, 2);
        do_free(12, 2, "R9 dropped release left block held");

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 9) < 5) do_alloc($urandom_range(0, UNITS + 1), "R4 random request");
            else random_free();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog expired actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule